// File: doc/BRIEF.md
# Instruction Address Breakpoint Comparator

This block is one hardware breakpoint unit for an instruction fetch path. Software programs an address register and a control register over a small register bus. On every fetch, the unit compares the fetched address, the size of the fetch, the security state and the processor mode against those settings. One cycle later it raises `bp_hit` if the breakpoint applies.

The address comparison works on 32-bit words. The two low bits of the programmed address are ignored. A four-bit lane mask then chooses which bytes of that word count. The fetch size and the low address bits determine which bytes the fetch touches, and the two sets must overlap. A security filter and a mode filter restrict where the breakpoint applies. The enable bit gates the whole unit. A mismatch select inverts only the address condition, so the breakpoint fires on every fetch outside the programmed lanes while the filters still apply.

Top module: `ibp_comparator`

## Requirements
- R1: Writes and reset. When `reg_wr` is high at a rising clock edge, `reg_wdata` is written to the register chosen by `reg_sel`: 0 selects the address register and 1 selects the control register. `reg_rdata` combinationally returns the selected register and shows the written value from the next cycle. Reset clears both registers and `bp_hit`.
- R2: Address register bits. The address register reads back all 32 written bits.
- R2 (continued): Control register bits. Only control bits 16, 15:14, 8:5 and 2:0 are stored. Every other control bit reads as zero, and writing it has no effect.
- R3: Enable. Control bit 0 is the enable. While it is 0, `bp_hit` stays low.
- R4: Security filter. Control bits 15:14 select where the breakpoint applies. 00 means both states. 01 means only when `fetch_secure`=0. 10 means only when `fetch_secure`=1. 11 never matches.
- R5: Mode filter. Control bits 2:1 use the `cpu_mode` codes 000 user, 001 supervisor, 010 system, and 011 to 111 other privileged modes. 00 allows codes 000 to 010. 01 allows every code except 000. 10 allows only 000. 11 allows every code.
- R6: Word compare. The address condition requires `fetch_addr[31:2]` to equal bits 31:2 of the address register. Address register bits 1:0 have no effect.
- R7: Lane overlap. Control bits 8:5 select byte lanes: bit 5+k selects lane k, at byte offset k. Let o = `fetch_addr[1:0]`. A halfword fetch (`fetch_size`=01) touches lanes o and o+1, keeping only those at or below lane 3. A word fetch (10) touches lanes o through 3. Codes 00 and 11 touch no lane. The address condition also requires at least one touched lane to be selected. A lane mask of 0000 therefore never satisfies it.
- R8: Illegal lane masks. A lane mask where bit 8 differs from bit 7, or bit 6 differs from bit 5, never produces a hit, in either compare mode.
- R9: Mismatch mode. When control bit 16 is 1, the address condition (R6 with R7) is inverted. Enable, security and mode qualification are not inverted.
- R10: Timing. `bp_hit` is a register. In the cycle after an edge where `fetch_valid` was high, it equals the AND of R3, R4, R5, R8 and R9 for that fetch. After an edge where `fetch_valid` was low, it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the address register, 1 selects the control register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_size | input | 2 | 01 halfword, 10 word, other codes touch no lanes |
| fetch_secure | input | 1 | 1 when the processor is in Secure state |
| cpu_mode | input | 3 | Processor mode code (see R5) |
| bp_hit | output | 1 | Registered breakpoint hit |

## Verification
A register write is visible on `reg_rdata` one edge after the strobe. The bench drives every input on the falling edge and reads back on the next falling edge. A fetch presented before a rising edge produces `bp_hit` in the cycle after that edge. The bench samples it at the following falling edge, when no edge is in flight. The configuration is always written at least one edge before the fetch that depends on it, so every check sees settings that are already stable.

// File: rtl/ibp_pkg.sv
package ibp_pkg;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned LANES     = 4;
    localparam int unsigned MODE_W    = 3;
    localparam logic [31:0] CTRL_MASK = 32'h0001_C1E7;

    localparam logic [1:0] FS_HALF = 2'b01;
    localparam logic [1:0] FS_WORD = 2'b10;

    localparam logic [1:0] SEC_ANY  = 2'b00;
    localparam logic [1:0] SEC_NS   = 2'b01;
    localparam logic [1:0] SEC_S    = 2'b10;

    localparam logic [1:0] MF_USR_SYS_SVC = 2'b00;
    localparam logic [1:0] MF_PRIV        = 2'b01;
    localparam logic [1:0] MF_USER        = 2'b10;
    localparam logic [1:0] MF_ANY         = 2'b11;

    localparam logic [MODE_W-1:0] MODE_USER = 3'd0;
    localparam logic [MODE_W-1:0] MODE_SVC  = 3'd1;
    localparam logic [MODE_W-1:0] MODE_SYS  = 3'd2;

    typedef struct packed {
        logic             mismatch;
        logic [1:0]       sec_filt;
        logic [LANES-1:0] lane_sel;
        logic [1:0]       mode_filt;
        logic             enable;
    } bp_cfg_t;
endpackage

// File: rtl/ibp_regs.sv
module ibp_regs
    import ibp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [ADDR_W-1:2] cmp_word,
    output bp_cfg_t           cfg
);
    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] ctrl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            if (sel) r_d.ctrl = wdata & CTRL_MASK;
            else     r_d.addr = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata         = sel ? r_q.ctrl : r_q.addr;
    assign cmp_word      = r_q.addr[ADDR_W-1:2];
    assign cfg.mismatch  = r_q.ctrl[16];
    assign cfg.sec_filt  = r_q.ctrl[15:14];
    assign cfg.lane_sel  = r_q.ctrl[8:5];
    assign cfg.mode_filt = r_q.ctrl[2:1];
    assign cfg.enable    = r_q.ctrl[0];
endmodule

// File: rtl/ibp_qualify.sv
module ibp_qualify
    import ibp_pkg::*;
(
    input  logic [1:0]        sec_filt,
    input  logic [1:0]        mode_filt,
    input  logic              fetch_secure,
    input  logic [MODE_W-1:0] cpu_mode,
    output logic              sec_ok,
    output logic              mode_ok
);
    logic is_user;
    logic is_basic;

    assign is_user  = (cpu_mode == MODE_USER);
    assign is_basic = is_user || (cpu_mode == MODE_SVC) || (cpu_mode == MODE_SYS);

    always_comb begin
        unique case (sec_filt)
            SEC_ANY: sec_ok = 1'b1;
            SEC_NS:  sec_ok = !fetch_secure;
            SEC_S:   sec_ok = fetch_secure;
            default: sec_ok = 1'b0;
        endcase
    end

    always_comb begin
        unique case (mode_filt)
            MF_USR_SYS_SVC: mode_ok = is_basic;
            MF_PRIV:        mode_ok = !is_user;
            MF_USER:        mode_ok = is_user;
            MF_ANY:         mode_ok = 1'b1;
            default:        mode_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/ibp_lane_match.sv
module ibp_lane_match
    import ibp_pkg::*;
(
    input  logic [ADDR_W-1:2] cmp_word,
    input  logic [LANES-1:0]  lane_sel,
    input  logic              mismatch,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [1:0]        fetch_size,
    output logic              addr_cond,
    output logic              lanes_legal
);
    localparam int unsigned OFF_W = $clog2(LANES);

    logic [LANES-1:0] touched;
    logic [OFF_W-1:0] off;
    logic             word_eq;
    logic             overlap;

    assign off = fetch_addr[OFF_W-1:0];

    always_comb begin
        unique case (fetch_size)
            FS_HALF: touched = LANES'(4'b0011) << off;
            FS_WORD: touched = {LANES{1'b1}} << off;
            default: touched = '0;
        endcase
    end

    assign word_eq     = (fetch_addr[ADDR_W-1:2] == cmp_word);
    assign overlap     = |(touched & lane_sel);
    assign lanes_legal = (lane_sel[3] == lane_sel[2]) && (lane_sel[1] == lane_sel[0]);
    assign addr_cond   = (word_eq && overlap) ^ mismatch;
endmodule

// File: rtl/ibp_comparator.sv
module ibp_comparator
    import ibp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [1:0]        fetch_size,
    input  logic              fetch_secure,
    input  logic [MODE_W-1:0] cpu_mode,
    output logic              bp_hit
);
    bp_cfg_t           cfg;
    logic [ADDR_W-1:2] cmp_word;
    logic              sec_ok, mode_ok, addr_cond, lanes_legal;
    logic              hit_d, hit_q;

    ibp_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cmp_word (cmp_word),
        .cfg      (cfg)
    );

    ibp_qualify u_qual (
        .sec_filt     (cfg.sec_filt),
        .mode_filt    (cfg.mode_filt),
        .fetch_secure (fetch_secure),
        .cpu_mode     (cpu_mode),
        .sec_ok       (sec_ok),
        .mode_ok      (mode_ok)
    );

    ibp_lane_match u_lane (
        .cmp_word    (cmp_word),
        .lane_sel    (cfg.lane_sel),
        .mismatch    (cfg.mismatch),
        .fetch_addr  (fetch_addr),
        .fetch_size  (fetch_size),
        .addr_cond   (addr_cond),
        .lanes_legal (lanes_legal)
    );

    always_comb begin
        hit_d = fetch_valid && cfg.enable && sec_ok && mode_ok
                && lanes_legal && addr_cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit_d;
    end

    assign bp_hit = hit_q;
endmodule

// File: rtl/ibp_checker.sv
module ibp_checker
    import ibp_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_sel,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        fetch_valid,
    input bp_cfg_t     cfg,
    input logic        bp_hit
);
    // R1 / R2: a control write reads back masked on the next cycle
    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel) ##1 reg_sel |-> reg_rdata == ($past(reg_wdata) & CTRL_MASK));

    // R2: unstored control bits always read zero
    assert_ctrl_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (reg_rdata & ~CTRL_MASK) == 32'h0);

    // R3: disabled breakpoint never hits
    assert_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.enable |=> !bp_hit);

    // R4: reserved security code never hits
    assert_sec_rsvd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sec_filt == 2'b11) |=> !bp_hit);

    // R8: illegal lane mask never hits
    assert_bad_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.lane_sel[3] != cfg.lane_sel[2]) || (cfg.lane_sel[1] != cfg.lane_sel[0])) |=> !bp_hit);

    // R10: no fetch, no hit
    assert_no_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !bp_hit);
endmodule

bind ibp_comparator ibp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .fetch_valid (fetch_valid),
    .cfg         (cfg),
    .bp_hit      (bp_hit)
);

// File: tb/tb_ibp_comparator.sv
`timescale 1ns/100ps
module tb_ibp_comparator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [1:0]  fetch_size = 2'b10;
    logic        fetch_secure = 1'b0;
    logic [2:0]  cpu_mode = 3'd0;
    logic        bp_hit;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] sh_addr;
    logic [31:0] sh_ctrl;

    always #2.5 clk = ~clk;

    ibp_comparator dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .fetch_size(fetch_size), .fetch_secure(fetch_secure),
        .cpu_mode(cpu_mode), .bp_hit(bp_hit)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic model(input logic [31:0] c, input logic [31:0] v,
                                   input logic [31:0] a, input logic [1:0] sz,
                                   input logic s, input logic [2:0] m);
        logic sok, mok, legal, am;
        logic [3:0] bas, touch;
        bas   = c[8:5];
        sok   = (c[15:14] == 2'b00) || (c[15:14] == 2'b01 && !s) || (c[15:14] == 2'b10 && s);
        mok   = (c[2:1] == 2'b11) || (c[2:1] == 2'b00 && m <= 3'd2)
             || (c[2:1] == 2'b01 && m != 3'd0) || (c[2:1] == 2'b10 && m == 3'd0);
        legal = (bas[3] == bas[2]) && (bas[1] == bas[0]);
        touch = (sz == 2'b01) ? 4'(4'b0011 << a[1:0]) :
                (sz == 2'b10) ? 4'(4'b1111 << a[1:0]) : 4'b0000;
        am    = (a[31:2] == v[31:2]) && ((touch & bas) != 4'b0);
        return c[0] && sok && mok && legal && (am ^ c[16]);
    endfunction

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (sel) sh_ctrl = d & 32'h0001_C1E7; else sh_addr = d;
    endtask

    // drive a fetch at a falling edge, sample bp_hit at the next falling edge
    task automatic fetch(input string req, input logic [31:0] a, input logic [1:0] sz,
                         input logic s, input logic [2:0] m, input logic exp);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = a; fetch_size = sz; fetch_secure = s; cpu_mode = m;
        @(negedge clk);
        fetch_valid = 1'b0;
        check(req, {31'b0, bp_hit}, {31'b0, exp});
    endtask

    task automatic t_reset;
        reg_sel = 1'b0; #0.1; check("R1 reset addr", reg_rdata, 32'h0);
        reg_sel = 1'b1; #0.1; check("R1 reset ctrl", reg_rdata, 32'h0);
        check("R1 reset hit", {31'b0, bp_hit}, 32'h0);
    endtask

    task automatic t_regs;
        wr_reg(1'b0, 32'hDEAD_BEEF);
        reg_sel = 1'b0; #0.1; check("R1 addr readback", reg_rdata, 32'hDEAD_BEEF);
        check("R2 addr all bits", reg_rdata, 32'hDEAD_BEEF);
        wr_reg(1'b1, 32'hFFFF_FFFF);
        reg_sel = 1'b1; #0.1; check("R2 ctrl masked", reg_rdata, 32'h0001_C1E7);
        wr_reg(1'b1, 32'hFFFE_3E18);
        reg_sel = 1'b1; #0.1; check("R2 rsvd ignored", reg_rdata, 32'h0);
    endtask

    task automatic t_enable;
        wr_reg(1'b0, 32'h0000_1003);
        wr_reg(1'b1, 32'h0000_01E6);
        fetch("R3 disabled", 32'h0000_1000, 2'b10, 1'b0, 3'd0, 1'b0);
        wr_reg(1'b1, 32'h0000_01E7);
        fetch("R3 enabled", 32'h0000_1000, 2'b10, 1'b0, 3'd0, 1'b1);
        fetch("R6 addr low bits ignored", 32'h0000_1002, 2'b01, 1'b0, 3'd0, 1'b1);
        fetch("R6 other word", 32'h0000_1004, 2'b10, 1'b0, 3'd0, 1'b0);
    endtask

    task automatic t_security;
        for (int f = 0; f < 4; f++) begin
            for (int s = 0; s < 2; s++) begin
                wr_reg(1'b1, 32'h0000_01E7 | (32'(f) << 14));
                fetch("R4 security filter", 32'h0000_1000, 2'b10, 1'(s), 3'd1,
                      model(sh_ctrl, sh_addr, 32'h0000_1000, 2'b10, 1'(s), 3'd1));
            end
        end
        wr_reg(1'b1, 32'h0000_C1E7);
        fetch("R4 reserved code", 32'h0000_1000, 2'b10, 1'b1, 3'd1, 1'b0);
    endtask

    task automatic t_mode;
        for (int f = 0; f < 4; f++) begin
            for (int m = 0; m < 8; m++) begin
                wr_reg(1'b1, 32'h0000_01E1 | (32'(f) << 1));
                fetch("R5 mode filter", 32'h0000_1000, 2'b10, 1'b0, 3'(m),
                      model(sh_ctrl, sh_addr, 32'h0000_1000, 2'b10, 1'b0, 3'(m)));
            end
        end
    endtask

    task automatic t_lanes;
        for (int b = 0; b < 16; b++) begin
            for (int mm = 0; mm < 2; mm++) begin
                wr_reg(1'b1, 32'h0000_0007 | (32'(b) << 5) | (32'(mm) << 16));
                for (int o = 0; o < 4; o++) begin
                    for (int z = 0; z < 4; z++) begin
                        fetch("R7 R8 R9 lane sweep", 32'h0000_1000 + 32'(o), 2'(z), 1'b0, 3'd3,
                              model(sh_ctrl, sh_addr, 32'h0000_1000 + 32'(o), 2'(z), 1'b0, 3'd3));
                    end
                end
            end
        end
        wr_reg(1'b1, 32'h0000_0067);
        fetch("R7 low half", 32'h0000_1000, 2'b01, 1'b0, 3'd0, 1'b1);
        fetch("R7 high half miss", 32'h0000_1002, 2'b01, 1'b0, 3'd0, 1'b0);
        wr_reg(1'b1, 32'h0000_0007);
        fetch("R7 empty mask", 32'h0000_1000, 2'b10, 1'b0, 3'd0, 1'b0);
        wr_reg(1'b1, 32'h0001_00A7);
        fetch("R8 illegal mask mismatch", 32'h0000_2000, 2'b10, 1'b0, 3'd0, 1'b0);
    endtask

    task automatic t_mismatch;
        wr_reg(1'b1, 32'h0001_01E7);
        fetch("R9 same word no hit", 32'h0000_1000, 2'b10, 1'b0, 3'd0, 1'b0);
        fetch("R9 other word hits", 32'h0000_5550, 2'b10, 1'b0, 3'd0, 1'b1);
        wr_reg(1'b1, 32'h0001_41E7);
        fetch("R9 filter not inverted", 32'h0000_5550, 2'b10, 1'b1, 3'd0, 1'b0);
    endtask

    task automatic t_timing;
        wr_reg(1'b1, 32'h0000_01E7);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = 32'h0000_1000; fetch_size = 2'b10;
        fetch_secure = 1'b0; cpu_mode = 3'd0;
        #0.1; check("R10 not before edge", {31'b0, bp_hit}, 32'h0);
        @(negedge clk);
        check("R10 one cycle later", {31'b0, bp_hit}, 32'h1);
        fetch_valid = 1'b0;
        @(negedge clk);
        check("R10 drops without fetch", {31'b0, bp_hit}, 32'h0);
    endtask

    initial begin
        #50000000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        sh_addr = '0; sh_ctrl = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_regs();
        t_enable();
        t_security();
        t_mode();
        t_lanes();
        t_mismatch();
        t_timing();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule